// File: doc/BRIEF.md
# Filtered Branch Record Ring Buffer

This block keeps a short history of taken control-flow transfers. Each transfer arrives already classified, with its kind, the privilege of its target, and three status flags. A transfer that passes the capture filter is written as a pair of words into a circular buffer. The source word carries the flags in its top bits and the target word holds the full target address. A pointer to the newest entry advances on every capture and wraps at the buffer depth. The entry k steps back from the newest sits at index (newest - k) mod depth.

The capture filter works by suppression: each set bit of a select register drops one class of transfer. One further select bit switches the buffer into a call-stack mode. In that mode calls push an entry, returns pop one without writing, and other kinds are not recorded. A freeze control stops capture after a performance interrupt until software releases it. Freezing is never applied in call-stack mode.

Software uses a register port for several tasks. It reads and writes every entry, and it reads or restores the newest-entry pointer. It also reads and writes the select register and issues a clear of the whole buffer.

Top module: `branch_trail`

## Requirements
- R1: After reset the newest-entry pointer is 0, the select register is 0, every entry word is 0, capture is not frozen, and reg_rdata and reg_rvalid are 0.
- R2: Outside call-stack mode, a captured transfer first advances the pointer by one. It then writes the new slot. The source word gets bit 63 = mispredict, bit 62 = in-transaction, bit 61 = abort, and bits 60:0 = br_from[60:0]. The target word gets br_to unchanged. With no transfer and no register write, the pointer holds.
- R3: The select bits suppress capture when set, by kind code: bit 2 conditional (br_kind 0), bit 3 relative call (1), bit 4 indirect call (2), bit 5 near return (3), bit 6 indirect jump (4), bit 7 relative jump (5), bit 8 far branch (6). Kind code 7 is never captured.
- R4: Privilege filtering uses the target only. Bit 0 suppresses transfers whose target is at ring 0 (br_to_kernel = 1). Bit 1 suppresses transfers whose target is above ring 0 (br_to_kernel = 0).
- R5: With select bit 9 set (call-stack mode), a call (kind 1 or 2) advances the pointer and writes the entry. A return (kind 3) moves the pointer back by one and writes nothing. All other kinds are dropped. The suppress bits still apply.
- R6: When frz_en is high, a pmi pulse freezes capture from the next cycle on. A frz_release pulse ends the freeze.
- R7: A pmi arriving in call-stack mode does not freeze capture, and an existing freeze does not block capture in call-stack mode.
- R8: With rec_en low, no transfer is captured.
- R9: Register space is selected by reg_space: 0 = source words, 1 = target words, 2 = control. Within the control space, reg_idx 0 = pointer, 1 = select, and 2 = clear on write. A read issued in one cycle returns reg_rdata with reg_rvalid in the next cycle. Only select bits 9:0 are stored, and the upper bits read as 0.
- R10: Writing the pointer restores it to the written value. Any register write in a cycle blocks the capture of a transfer offered in that cycle.
- R11: A write to the clear index zeroes every source and target word and the pointer, and leaves the select register unchanged.
- R12: The pointer wraps modulo the depth in both directions: a push from depth-1 gives 0, and a pop from 0 gives depth-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rec_en | input | 1 | Global capture enable |
| frz_en | input | 1 | Freeze capture on performance interrupt |
| pmi | input | 1 | Performance interrupt pulse |
| frz_release | input | 1 | Ends a freeze |
| br_valid | input | 1 | A classified transfer is offered |
| br_kind | input | 3 | Transfer kind code |
| br_to_kernel | input | 1 | Target privilege is ring 0 |
| br_mispred | input | 1 | Transfer was mispredicted |
| br_in_tx | input | 1 | Transfer was inside a transaction |
| br_abort | input | 1 | Transfer was a transaction abort |
| br_from | input | XLEN | Source address |
| br_to | input | XLEN | Target address |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_space | input | 2 | Register space select |
| reg_idx | input | IW | Entry or control index |
| reg_wdata | input | XLEN | Write data |
| reg_rdata | output | XLEN | Read data, one cycle after reg_re |
| reg_rvalid | output | 1 | Read data valid |

## Verification
The bench packs flag bits on top of a source address with upper ones set. A design that forgot to overwrite bits 63:61 would return a different top nibble. It pulls a return in call-stack mode and reads back the popped slot. A design that logged returns would overwrite the entry, and one that did not decrement would leave the pointer too high. It wraps the pointer in both directions, offers a capture in the same cycle as a register write, and raises a performance interrupt while in call-stack mode. A design that froze there would stop recording calls. It also writes all ones to the select register, where keeping bits above 9 would show in the read-back.

// File: rtl/branch_trail.sv
module branch_trail #(
  parameter int DEPTH = 16,
  parameter int XLEN  = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rec_en,
  input  logic            frz_en,
  input  logic            pmi,
  input  logic            frz_release,
  input  logic            br_valid,
  input  logic [2:0]      br_kind,
  input  logic            br_to_kernel,
  input  logic            br_mispred,
  input  logic            br_in_tx,
  input  logic            br_abort,
  input  logic [XLEN-1:0] br_from,
  input  logic [XLEN-1:0] br_to,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [1:0]      reg_space,
  input  logic [IW-1:0]   reg_idx,
  input  logic [XLEN-1:0] reg_wdata,
  output logic [XLEN-1:0] reg_rdata,
  output logic            reg_rvalid
);

  localparam logic [1:0]    SP_FROM = 2'd0;
  localparam logic [1:0]    SP_TO   = 2'd1;
  localparam logic [1:0]    SP_CTRL = 2'd2;
  localparam logic [IW-1:0] CI_TOS  = IW'(0);
  localparam logic [IW-1:0] CI_SEL  = IW'(1);
  localparam logic [IW-1:0] CI_CLR  = IW'(2);

  logic [XLEN-1:0] from_q [DEPTH];
  logic [XLEN-1:0] to_q   [DEPTH];
  logic [IW-1:0]   tos_q;
  logic [9:0]      sel_q;
  logic            frozen_q;

  wire cs_mode = sel_q[9];

  logic [3:0] kind_bit;
  assign kind_bit = {1'b0, br_kind} + 4'd2;

  wire kind_ok = (br_kind != 3'd7);
  wire priv_sup = br_to_kernel ? sel_q[0] : sel_q[1];
  wire suppress = priv_sup | ~kind_ok | sel_q[kind_bit];
  wire is_call  = (br_kind == 3'd1) || (br_kind == 3'd2);
  wire is_ret   = (br_kind == 3'd3);

  wire take = br_valid & rec_en & ~reg_we & ~(frozen_q & ~cs_mode) & ~suppress;
  wire push = take & (~cs_mode | is_call);
  wire pop  = take & cs_mode & is_ret;

  wire wr_ctrl = reg_we & (reg_space == SP_CTRL);
  wire wr_tos  = wr_ctrl & (reg_idx == CI_TOS);
  wire wr_sel  = wr_ctrl & (reg_idx == CI_SEL);
  wire clr     = wr_ctrl & (reg_idx == CI_CLR);

  logic [IW-1:0] tos_n;
  assign tos_n = tos_q + 1'b1;

  logic [XLEN-1:0] from_word;
  assign from_word = {br_mispred, br_in_tx, br_abort, br_from[XLEN-4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q    <= '0;
      sel_q    <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (clr)         tos_q <= '0;
      else if (wr_tos) tos_q <= reg_wdata[IW-1:0];
      else if (push)   tos_q <= tos_n;
      else if (pop)    tos_q <= tos_q - 1'b1;

      if (wr_sel) sel_q <= reg_wdata[9:0];

      if (pmi && frz_en && !cs_mode) frozen_q <= 1'b1;
      else if (frz_release)          frozen_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    wire hit   = push && (tos_n == IW'(g));
    wire wr_f  = reg_we && (reg_space == SP_FROM) && (reg_idx == IW'(g));
    wire wr_t  = reg_we && (reg_space == SP_TO)   && (reg_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        from_q[g] <= '0;
        to_q[g]   <= '0;
      end else if (clr) begin
        from_q[g] <= '0;
        to_q[g]   <= '0;
      end else begin
        if (wr_f)     from_q[g] <= reg_wdata;
        else if (hit) from_q[g] <= from_word;
        if (wr_t)     to_q[g]   <= reg_wdata;
        else if (hit) to_q[g]   <= br_to;
      end
    end
  end

  logic [XLEN-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_space)
      SP_FROM: rd_mux = from_q[reg_idx];
      SP_TO:   rd_mux = to_q[reg_idx];
      SP_CTRL: begin
        if (reg_idx == CI_TOS)      rd_mux = {{(XLEN-IW){1'b0}}, tos_q};
        else if (reg_idx == CI_SEL) rd_mux = {{(XLEN-10){1'b0}}, sel_q};
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_re;
      if (reg_re) reg_rdata <= rd_mux;
    end
  end

  AST_TOS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !reg_we) |=> $stable(tos_q)); // R2
  AST_REC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_en && !reg_we) |=> $stable(tos_q)); // R8
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !sel_q[9] && !reg_we) |=> $stable(tos_q)); // R6
  AST_CS_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[9] && !frozen_q) |=> !frozen_q); // R7
  AST_CS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && rec_en && !reg_we && sel_q[9] && br_kind == 3'd3 && !sel_q[5]
     && !(br_to_kernel ? sel_q[0] : sel_q[1])) |=> tos_q == IW'($past(tos_q) - 1'b1)); // R5
  AST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> reg_rvalid); // R9
  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_space == 2'd2 && reg_idx == IW'(1)) |=> sel_q == $past(reg_wdata[9:0])); // R9

endmodule

// File: tb/branch_trail_test.sv
module branch_trail_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic rec_en = 1, frz_en = 0, pmi = 0, frz_release = 0;
  logic br_valid = 0, br_to_kernel = 0, br_mispred = 0, br_in_tx = 0, br_abort = 0;
  logic [2:0] br_kind = 0;
  logic [63:0] br_from = 0, br_to = 0, reg_wdata = 0;
  logic reg_we = 0, reg_re = 0;
  logic [1:0] reg_space = 0;
  logic [IW-1:0] reg_idx = 0;
  logic [63:0] reg_rdata;
  logic reg_rvalid;

  int checks = 0, fails = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];

  branch_trail #(.DEPTH(DEPTH), .XLEN(64)) uut (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .frz_en(frz_en), .pmi(pmi),
    .frz_release(frz_release), .br_valid(br_valid), .br_kind(br_kind),
    .br_to_kernel(br_to_kernel), .br_mispred(br_mispred), .br_in_tx(br_in_tx),
    .br_abort(br_abort), .br_from(br_from), .br_to(br_to), .reg_we(reg_we),
    .reg_re(reg_re), .reg_space(reg_space), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] sp, input int idx, input logic [63:0] e, input string t);
    reg_re = 1; reg_space = sp; reg_idx = IW'(idx);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic wr(input logic [1:0] sp, input int idx, input logic [63:0] d);
    reg_we = 1; reg_space = sp; reg_idx = IW'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic br(input logic [2:0] k, input logic kern, input logic [63:0] f, input logic [63:0] t,
                    input logic m, input logic x, input logic a);
    br_valid = 1; br_kind = k; br_to_kernel = kern; br_from = f; br_to = t;
    br_mispred = m; br_in_tx = x; br_abort = a;
    @(negedge clk);
    br_valid = 0;
  endtask

  task automatic pulse_pmi();
    pmi = 1; @(negedge clk); pmi = 0;
  endtask

  task automatic pulse_rel();
    frz_release = 1; @(negedge clk); frz_release = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (reg_rdata !== 64'd0 || reg_rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R1 outputs after reset: actual %h/%b expected 0/0", reg_rdata, reg_rvalid);
    end
    rd(2, 0, 64'd0, "R1 pointer");
    rd(2, 1, 64'd0, "R1 select");
    rd(0, 5, 64'd0, "R1 entry");

    br(3'd0, 0, 64'h1000, 64'h2000, 1, 0, 0);
    rd(2, 0, 64'd1, "R2 pointer advance");
    rd(0, 1, 64'h8000_0000_0000_1000, "R2 mispredict flag");
    rd(1, 1, 64'h2000, "R2 target word");
    br(3'd5, 0, 64'hFFFF_FFFF_FFFF_0100, 64'h3000, 0, 1, 0);
    rd(0, 2, 64'h5FFF_FFFF_FFFF_0100, "R2 flags over address");

    wr(2, 1, 64'hFFFF_FFFF);
    rd(2, 1, 64'h3FF, "R9 select width");
    wr(2, 1, 64'h004);
    br(3'd0, 0, 64'h1010, 64'h1020, 0, 0, 0);
    br(3'd1, 0, 64'h1100, 64'h1200, 0, 0, 0);
    rd(2, 0, 64'd3, "R3 conditional suppressed");
    rd(1, 3, 64'h1200, "R3 call kept");

    wr(2, 1, 64'h001);
    br(3'd5, 1, 64'h4000, 64'h4050, 0, 0, 0);
    br(3'd5, 0, 64'hFFFF_0000_0000_4000, 64'h4100, 0, 0, 0);
    rd(2, 0, 64'd4, "R4 target privilege");
    rd(1, 4, 64'h4100, "R4 user target kept");
    wr(2, 1, 64'h000);

    rec_en = 0;
    br(3'd0, 0, 64'h4200, 64'h4300, 0, 0, 0);
    rec_en = 1;
    rd(2, 0, 64'd4, "R8 capture disabled");

    frz_en = 1;
    pulse_pmi();
    br(3'd0, 0, 64'h4400, 64'h4500, 0, 0, 0);
    rd(2, 0, 64'd4, "R6 frozen");
    pulse_rel();
    br(3'd0, 0, 64'h5000, 64'h5100, 0, 0, 0);
    rd(2, 0, 64'd5, "R6 released");

    reg_we = 1; reg_space = 0; reg_idx = 0; reg_wdata = 64'h77;
    br_valid = 1; br_kind = 0; br_to_kernel = 0; br_from = 64'h5200; br_to = 64'h5300;
    @(negedge clk);
    reg_we = 0; br_valid = 0;
    rd(2, 0, 64'd5, "R10 write blocks capture");
    rd(0, 0, 64'h77, "R9 entry write");

    wr(2, 0, 64'd9);
    rd(2, 0, 64'd9, "R10 pointer restore");
    br(3'd0, 0, 64'h6000, 64'h6100, 0, 0, 0);
    rd(1, 10, 64'h6100, "R10 capture after restore");

    wr(2, 0, 64'd15);
    br(3'd0, 0, 64'hAA, 64'hBB, 0, 0, 0);
    rd(2, 0, 64'd0, "R12 push wrap");
    rd(0, 0, 64'hAA, "R12 wrapped slot");

    wr(2, 1, 64'h200);
    pulse_pmi();
    br(3'd1, 0, 64'h7000, 64'h7100, 0, 0, 0);
    br(3'd2, 0, 64'h8000, 64'h8100, 0, 0, 0);
    rd(2, 0, 64'd2, "R7 no freeze in call-stack mode");
    br(3'd3, 0, 64'h8200, 64'h8300, 0, 0, 0);
    rd(2, 0, 64'd1, "R5 return pops");
    rd(1, 2, 64'h8100, "R5 return writes nothing");
    br(3'd0, 0, 64'h8400, 64'h8500, 0, 0, 0);
    br(3'd5, 0, 64'h8600, 64'h8700, 0, 0, 0);
    rd(2, 0, 64'd1, "R5 other kinds dropped");
    br(3'd1, 0, 64'h9000, 64'h9100, 0, 0, 0);
    rd(1, 2, 64'h9100, "R5 call overwrites popped slot");

    wr(2, 0, 64'd0);
    br(3'd3, 0, 64'h9200, 64'h9300, 0, 0, 0);
    rd(2, 0, 64'd15, "R12 pop wrap");
    wr(2, 1, 64'h208);
    br(3'd1, 0, 64'h9400, 64'h9500, 0, 0, 0);
    rd(2, 0, 64'd15, "R5 suppress still applies");

    wr(2, 2, 64'd0);
    rd(2, 0, 64'd0, "R11 pointer cleared");
    rd(0, 1, 64'd0, "R11 source cleared");
    rd(1, 2, 64'd0, "R11 target cleared");
    rd(2, 1, 64'h208, "R11 select kept");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 reads pending: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule